// File: doc/BRIEF.md
# Erased Page Detector With Status

This block sits on the read path of a flash controller, directly after the error-correction decoder. It watches every data beat of a page as the page streams out and keeps a running count of the zero bits it has seen. At the last beat it combines that count with the decoder's verdict for the page. An uncorrectable page whose raw zero count stays below a programmable threshold is treated as a blank (erased) page. In that case the block raises an erased-page interrupt flag and suppresses the uncorrectable-error flag.

The block has one 32-bit configuration word. It holds the correction strength, which is passed on to the decoder, and the blank-detection threshold. The status word is sticky and is cleared by writing 1 to a bit. Detection is disabled by a threshold of 0. A threshold of 1 accepts only pages that contain no zero bits at all. A threshold of strength+1 tolerates up to strength flipped bits spread over the whole page. The block never alters the page data. The data that leaves the decoder may already have been modified by correction, so software must fill its buffer with all-ones itself when the erased flag is set.

Top module: `erased_page_detector`

## Requirements
- R1: The zero count restarts on a beat marked `beat_first`. Each accepted beat adds the number of 0 bits in `beat_data`, so the count of one page never carries into the next page.
- R2: When the last beat of a page is accepted with `ecc_uncorr`=1, a nonzero threshold and a final zero count strictly below the threshold, status bit 16 (erased) is set and status bit 0 (uncorrectable) is not set by that page.
- R3: `cfg_wdata` is captured when `cfg_we` is high. Bits 4:0 hold the correction strength, driven on `ecc_strength`. Bits 31:16 hold the erase threshold. All other bits read back as 0. The word resets to 0.
- R4: Status bit map: bit 0 means uncorrectable, bit 1 means page done, bit 15 means transfer incomplete (set when `page_short` is high with the last beat), and bit 16 means erased. All other bits always read 0, and the status word resets to 0.
- R5: The comparison is strict. A count equal to the threshold is not erased. With a threshold of 1, only a page with zero 0-bits is erased.
- R6: A threshold of 0 disables detection. An uncorrectable page then always sets bit 0 and never sets bit 16.
- R7: The zero counter saturates at its all-ones value (65535 by default) instead of wrapping.
- R8: The status bits for a page change at the clock edge that accepts the page's last beat (`beat_valid` and `beat_last` high), and not earlier.
- R9: Status bits are sticky until a write with `irq_clr_we` clears each bit given as 1 in `irq_clr_data`. A bit being set in the same cycle as it is cleared stays set.
- R10: A page ended with `ecc_uncorr`=0 sets only bit 1 (plus bit 15 if `page_short` is high). It never sets bit 0 or bit 16, whatever the count.
- R11: `irq` is high exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word readback |
| ecc_strength | output | 5 | Correction strength for the decoder |
| beat_valid | input | 1 | Data beat present |
| beat_first | input | 1 | Beat is the first of a page |
| beat_last | input | 1 | Beat is the last of a page |
| beat_data | input | DATA_W | Raw page data beat |
| ecc_uncorr | input | 1 | Decoder verdict with the last beat: page uncorrectable |
| page_short | input | 1 | With the last beat: transfer ended incomplete |
| irq_clr_we | input | 1 | Status clear strobe |
| irq_clr_data | input | 32 | Bits to clear (write 1 to clear) |
| irq_status | output | 32 | Sticky interrupt status word |
| irq | output | 1 | OR of all status bits |

## Verification
The bound checker watches several behaviours on every cycle. It checks that an uncorrectable page whose count is below a nonzero threshold raises the erased flag and not the uncorrectable flag. It checks that a zero threshold or a correctable verdict never raises the erased flag, that the counter holds once saturated, that each page end raises the done flag, and that the configuration readback and write-1-to-clear behave as required. Some behaviours can only be shown by the bench's scenarios, since they depend on whole pages. These are the exact count of zeros over multi-beat pages, the restart of the count from one page to the next, the equal-to-threshold boundary, saturation after more than 65535 zeros, and a set that wins over a clear arriving in the same cycle.

// File: rtl/epd_pkg.sv
package epd_pkg;
  localparam int CFG_W      = 32;
  localparam int STR_LSB    = 0;
  localparam int STR_W      = 5;
  localparam int THR_LSB    = 16;
  localparam int THR_W      = 16;
  localparam int ST_W       = 32;
  localparam int ST_UNCORR  = 0;
  localparam int ST_DONE    = 1;
  localparam int ST_SHORT   = 15;
  localparam int ST_ERASED  = 16;

  localparam logic [CFG_W-1:0] CFG_MASK =
    ({CFG_W{1'b0}} | ({STR_W{1'b1}} << STR_LSB)) | (CFG_W'({THR_W{1'b1}}) << THR_LSB);

  // strict below-threshold test, zero threshold never matches
  function automatic logic below_thr(input logic [31:0] cnt, input logic [31:0] thr);
    return (thr != 32'd0) && (cnt < thr);
  endfunction
endpackage

// File: rtl/epd_zero_counter.sv
module epd_zero_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic              beat_first,
  input  logic [DATA_W-1:0] beat_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_next
);
  localparam int PC_W = $clog2(DATA_W + 1);

  function automatic logic [PC_W-1:0] zeros_of(input logic [DATA_W-1:0] d);
    logic [PC_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + PC_W'(!d[i]);
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [PC_W-1:0]  b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] base;
  logic [PC_W-1:0]  beat_zeros;

  always_comb begin
    base       = beat_first ? '0 : cnt_q;
    beat_zeros = zeros_of(beat_data);
    cnt_next   = sat_add(base, beat_zeros);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (beat_valid) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/epd_cfg_reg.sv
module epd_cfg_reg
  import epd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [STR_W-1:0] strength,
  output logic [THR_W-1:0] threshold
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata & CFG_MASK;
  end

  assign strength  = cfg_q[STR_LSB +: STR_W];
  assign threshold = cfg_q[THR_LSB +: THR_W];
endmodule

// File: rtl/epd_classifier.sv
module epd_classifier
  import epd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             page_end,
  input  logic             ecc_uncorr,
  input  logic             page_short,
  input  logic [CNT_W-1:0] cnt_final,
  input  logic [THR_W-1:0] threshold,
  output logic             ev_erased,
  output logic             ev_uncorr,
  output logic [ST_W-1:0]  set_vec
);
  logic blank;

  always_comb begin
    blank     = below_thr(32'(cnt_final), 32'(threshold));
    ev_erased = page_end && ecc_uncorr && blank;
    ev_uncorr = page_end && ecc_uncorr && !blank;
    set_vec   = '0;
    set_vec[ST_DONE]   = page_end;
    set_vec[ST_SHORT]  = page_end && page_short;
    set_vec[ST_UNCORR] = ev_uncorr;
    set_vec[ST_ERASED] = ev_erased;
  end
endmodule

// File: rtl/epd_irq_status.sv
module epd_irq_status
  import epd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_vec,
  output logic [ST_W-1:0] status_q
);
  logic [ST_W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_eff) | set_vec;
  end
endmodule

// File: rtl/erased_page_detector.sv
module erased_page_detector
  import epd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [4:0]        ecc_strength,
  input  logic              beat_valid,
  input  logic              beat_first,
  input  logic              beat_last,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              ecc_uncorr,
  input  logic              page_short,
  input  logic              irq_clr_we,
  input  logic [31:0]       irq_clr_data,
  output logic [31:0]       irq_status,
  output logic              irq
);
  logic             page_end;
  logic [CNT_W-1:0] zcnt_q;
  logic [CNT_W-1:0] zcnt_next;
  logic [THR_W-1:0] threshold;
  logic             ev_erased;
  logic             ev_uncorr;
  logic [ST_W-1:0]  set_vec;

  assign page_end = beat_valid && beat_last;

  epd_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_rdata), .strength(ecc_strength), .threshold(threshold)
  );

  epd_zero_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_first(beat_first),
    .beat_data(beat_data), .cnt_q(zcnt_q), .cnt_next(zcnt_next)
  );

  epd_classifier #(.CNT_W(CNT_W)) u_cls (
    .page_end(page_end), .ecc_uncorr(ecc_uncorr), .page_short(page_short),
    .cnt_final(zcnt_next), .threshold(threshold),
    .ev_erased(ev_erased), .ev_uncorr(ev_uncorr), .set_vec(set_vec)
  );

  epd_irq_status u_st (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(irq_clr_we),
    .clr_vec(irq_clr_data), .status_q(irq_status)
  );

  assign irq = |irq_status;
endmodule

// File: rtl/epd_checker.sv
module epd_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             page_end,
  input logic             ecc_uncorr,
  input logic             beat_valid,
  input logic             beat_first,
  input logic [CNT_W-1:0] zcnt_q,
  input logic [CNT_W-1:0] zcnt_next,
  input logic [15:0]      thr,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             irq_clr_we,
  input logic [31:0]      irq_clr_data,
  input logic [31:0]      irq_status
);
  localparam logic [31:0] MASK = 32'hFFFF_001F;
  logic blank_now;
  assign blank_now = (thr != 16'd0) && (32'(zcnt_next) < 32'(thr));

  p_erased_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_end && ecc_uncorr && blank_now |=> irq_status[16]);

  p_no_uncorr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_end && ecc_uncorr && blank_now && !irq_status[0] |=> !irq_status[0]);

  p_thr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_end && thr == 16'd0 |=> !$rose(irq_status[16]));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_first && (&zcnt_q) |=> (&zcnt_q));

  p_cfg_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & MASK));

  p_done_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_end |=> irq_status[1]);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_we && irq_clr_data[1] && !page_end |=> !irq_status[1]);

  p_correctable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    page_end && !ecc_uncorr && !irq_status[0] && !irq_status[16]
    |=> !irq_status[0] && !irq_status[16]);
endmodule

bind erased_page_detector epd_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .page_end(page_end), .ecc_uncorr(ecc_uncorr),
  .beat_valid(beat_valid), .beat_first(beat_first), .zcnt_q(zcnt_q),
  .zcnt_next(zcnt_next), .thr(threshold), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .irq_clr_we(irq_clr_we), .irq_clr_data(irq_clr_data),
  .irq_status(irq_status)
);

// File: tb/erased_page_detector_tb.sv
`timescale 1ns/1ps
module erased_page_detector_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [4:0]  ecc_strength;
  logic        beat_valid = 0, beat_first = 0, beat_last = 0;
  logic [31:0] beat_data = 0;
  logic        ecc_uncorr = 0, page_short = 0;
  logic        irq_clr_we = 0;
  logic [31:0] irq_clr_data = 0;
  logic [31:0] irq_status;
  logic        irq;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;
  int cur_thr = 0;

  always #2 clk = ~clk;

  erased_page_detector dut_i (.*);

  function automatic int zeros32(input logic [31:0] d);
    int n = 0;
    for (int i = 0; i < 32; i++) if (d[i] == 1'b0) n++;
    return n;
  endfunction

  function automatic logic [31:0] expect_st(input int cnt, input int thr,
                                            input bit unc, input bit sh);
    logic [31:0] e = 32'h2;
    int c = (cnt > 65535) ? 65535 : cnt;
    if (sh) e[15] = 1'b1;
    if (unc) begin
      if (thr != 0 && c < thr) e[16] = 1'b1;
      else                     e[0]  = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
    cur_thr = int'(w[31:16]);
  endtask

  task automatic clear_bits(input logic [31:0] m);
    @(negedge clk); irq_clr_we = 1; irq_clr_data = m;
    @(negedge clk); irq_clr_we = 0; irq_clr_data = 0;
  endtask

  // mode: 0 all ones, 1 sparse flips, 2 random, 3 all zeros, 4 exactly nz zeros in first beat
  task automatic send_page(input int nb, input int mode, input int nz, input bit unc,
                           input bit sh, input bit pre_chk, output int cnt);
    logic [31:0] d;
    cnt = 0;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      case (mode)
        0: d = '1;
        1: d = ($urandom % 3 == 0) ? ~(32'h1 << ($urandom % 32)) : '1;
        2: d = $urandom;
        3: d = '0;
        default: d = (b == 0) ? ~((32'h1 << nz) - 32'h1) : '1;
      endcase
      cnt += zeros32(d);
      beat_valid = 1; beat_data = d; beat_first = (b == 0); beat_last = (b == nb - 1);
      ecc_uncorr = (b == nb - 1) ? unc : 1'b0;
      page_short = (b == nb - 1) ? sh : 1'b0;
      if (pre_chk && b == nb - 1) begin
        #1 check("R8 no status before last edge", irq_status, 32'h0);
      end
    end
    @(negedge clk);
    beat_valid = 0; beat_first = 0; beat_last = 0; ecc_uncorr = 0; page_short = 0;
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk); cycles++;
      if (cycles > 150000 && !finished) begin
        fails++; finished = 1;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    int cnt;
    process::self().srandom(32'd1357);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R3 cfg reset", cfg_rdata, 32'h0);
    check("R4 status reset", irq_status, 32'h0);
    check("R11 irq reset", {31'b0, irq}, 32'h0);

    write_cfg(32'hFFFF_FFFF);
    check("R3 cfg mask", cfg_rdata, 32'hFFFF_001F);
    check("R3 strength out", {27'b0, ecc_strength}, 32'h1F);

    write_cfg(32'h0001_0008);
    send_page(4, 0, 0, 1, 0, 1, cnt);
    check("R2 erased clean page", irq_status, 32'h0001_0002);
    check("R11 irq set", {31'b0, irq}, 32'h1);
    clear_bits('1);
    send_page(4, 4, 1, 1, 0, 1, cnt);
    check("R5 thr1 one zero", irq_status, 32'h3);
    clear_bits('1);

    write_cfg(32'h0005_0004);
    send_page(3, 4, 5, 1, 0, 1, cnt);
    check("R5 count equal thr", irq_status, 32'h3);
    clear_bits('1);
    send_page(3, 4, 4, 1, 0, 1, cnt);
    check("R5 count below thr", irq_status, 32'h0001_0002);
    clear_bits('1);

    write_cfg(32'h0000_0004);
    send_page(2, 0, 0, 1, 0, 1, cnt);
    check("R6 thr zero", irq_status, 32'h3);
    clear_bits('1);

    write_cfg(32'h0064_0004);
    send_page(2, 0, 0, 0, 0, 1, cnt);
    check("R10 correctable", irq_status, 32'h2);
    clear_bits('1);
    send_page(2, 0, 0, 0, 1, 1, cnt);
    check("R4 short flag", irq_status, 32'h0000_8002);
    clear_bits('1);

    write_cfg(32'h0001_0004);
    send_page(3, 3, 0, 0, 0, 1, cnt);
    clear_bits('1);
    send_page(2, 0, 0, 1, 0, 1, cnt);
    check("R1 count restarts", irq_status, 32'h0001_0002);

    clear_bits(32'h2);
    check("R9 clear one bit", irq_status, 32'h0001_0000);
    repeat (5) @(negedge clk);
    check("R9 sticky", irq_status, 32'h0001_0000);
    clear_bits('1);

    send_page(1, 0, 0, 0, 0, 1, cnt);
    @(negedge clk);
    beat_valid = 1; beat_first = 1; beat_last = 1; beat_data = '1; ecc_uncorr = 0;
    irq_clr_we = 1; irq_clr_data = 32'h2;
    @(negedge clk);
    beat_valid = 0; beat_first = 0; beat_last = 0; irq_clr_we = 0; irq_clr_data = 0;
    check("R9 set wins over clear", irq_status, 32'h2);
    clear_bits('1);

    write_cfg(32'hFFFF_0004);
    send_page(2050, 3, 0, 1, 0, 1, cnt);
    check("R7 saturation", irq_status, expect_st(cnt, 65535, 1, 0));
    clear_bits('1);

    for (int p = 0; p < 150; p++) begin
      int nb = 1 + ($urandom % 6);
      int md = $urandom % 4;
      bit un = $urandom % 2;
      bit sh = ($urandom % 5) == 0;
      int sel = $urandom % 4;
      logic [15:0] th = (sel == 0) ? 16'd0 : (sel == 1) ? 16'd1 :
                        (sel == 2) ? 16'($urandom % 12) : 16'($urandom);
      write_cfg({th, 11'b0, 5'($urandom)});
      send_page(nb, md, 0, un, sh, 1, cnt);
      check(un ? "R2 random uncorr page" : "R10 random correctable page",
            irq_status, expect_st(cnt, cur_thr, un, sh));
      check("R11 irq random", {31'b0, irq}, 32'h1);
      clear_bits('1);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule